// File: doc/BRIEF.md
# Pointer-Pair Data Address Generator

This block works out the byte address for each memory access of an 8-bit register-file microcontroller. Three 16-bit pointers are each made from two neighbouring 8-bit registers. The surrounding core gives the block four things: the addressing mode, which pointer to use, a 6-bit unsigned displacement, and the current value of that pointer as read from the register file.

One clock later the block returns the effective address. It also returns a region code that says whether the address falls in the register file, the I/O registers or general RAM, or whether the access reads a program-memory constant. For a program-memory read the address is also split into a 16-bit word address and a byte-lane select. In the modes that change the pointer, the block returns the new pointer value together with the register numbers of its low and high halves and a separate write enable for each half.

A two-state controller (`ST_IDLE`, `ST_ISSUE`) marks which output cycles carry a result. The transition `GO` moves from `ST_IDLE` to `ST_ISSUE` when a request is present. The transition `REPEAT` keeps the controller in `ST_ISSUE` for back-to-back requests. The transition `DRAIN` returns it to `ST_IDLE` when no request arrives.

Top module: `ptr_agu`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `out_valid`, `wb_lo_en` and `wb_hi_en` are 0.
- R2: A request sampled on a clock edge produces `out_valid`=1 with its results after that edge. A cycle with no request gives `out_valid`=0 and both write enables 0.
- R3: Pointer select 0 names registers 26/27, select 1 names 28/29, and select 2 or 3 names 30/31 (low byte / high byte). Program-memory modes (4 and 5) always name 30/31. `wb_lo_idx` and `wb_hi_idx` carry these numbers whenever `out_valid` is 1.
- R4: In mode 0 (plain indirect), and in the unused codes 6 and 7, the address equals the pointer and there is no write-back.
- R5: In mode 1 (post-increment), the address is the pointer and the write-back value is pointer+1 modulo 2^16.
- R6: In mode 2 (pre-decrement), the address is pointer−1 modulo 2^16, and that same value is written back.
- R7: In mode 3 (displacement), the address is pointer plus the zero-extended 6-bit displacement, modulo 2^16. There is no write-back.
- R8: `wb_lo_en` is 1 exactly when the mode writes the pointer back. `wb_hi_en` is 1 only when, in addition, the new high byte differs from the old one.
- R9: In data modes (0–3, 6, 7) the region is 0 for addresses 0–31 (register file), 1 for addresses 32–95 (I/O) and 2 for addresses 96 and above (RAM).
- R10: In mode 4 (program-memory constant) the address is the pointer, the region is 3, `pm_word` is address bits 15:1, `pm_hi_byte` is address bit 0, and there is no write-back.
- R11: Mode 5 (program-memory post-increment) behaves like mode 4, and in addition writes back pointer+1 modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | An access is presented this cycle |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer choice: 0, 1, or 2/3 |
| disp | input | 6 | Unsigned displacement |
| ptr_val | input | 16 | Current value of the selected pointer |
| out_valid | output | 1 | Outputs carry a result |
| ea | output | 16 | Effective byte address |
| region | output | 2 | 0 register file, 1 I/O, 2 RAM, 3 program memory |
| pm_word | output | 15 | Program-memory word address |
| pm_hi_byte | output | 1 | Upper byte of the program word selected |
| wb_data | output | 16 | New pointer value |
| wb_lo_en | output | 1 | Write the low pointer register |
| wb_hi_en | output | 1 | Write the high pointer register |
| wb_lo_idx | output | 5 | Register number of the low byte |
| wb_hi_idx | output | 5 | Register number of the high byte |

## Verification
The assertions assume that `ptr_val` holds the value of the pointer that the mode names. For the program-memory modes this means the core supplies the Z-type pointer, whatever `ptr_sel` says. The block itself never checks this relation, so it stays correct for any input. The stimulus sweeps every mode code against every select value. Pointer values are chosen at 0x0000, 0xFFFF, byte-carry edges and each region boundary, with the displacement at its extremes. Idle gaps are mixed in so that every controller transition occurs.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        AM_IND        = 3'd0,
        AM_POSTINC    = 3'd1,
        AM_PREDEC     = 3'd2,
        AM_DISP       = 3'd3,
        AM_PM_READ    = 3'd4,
        AM_PM_POSTINC = 3'd5,
        AM_SPARE6     = 3'd6,
        AM_SPARE7     = 3'd7
    } amode_t;

    typedef enum logic [1:0] {
        RG_REGFILE = 2'd0,
        RG_IO      = 2'd1,
        RG_RAM     = 2'd2,
        RG_PROG    = 2'd3
    } region_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } agu_state_t;

    function automatic logic is_pm_mode(input amode_t m);
        return (m == AM_PM_READ) || (m == AM_PM_POSTINC);
    endfunction

endpackage

// File: rtl/agu_pointer_math.sv
module agu_pointer_math
    import agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int QW = 6
) (
    input  amode_t          mode,
    input  logic [AW-1:0]   ptr,
    input  logic [QW-1:0]   disp,
    output logic [AW-1:0]   addr,
    output logic [AW-1:0]   next_ptr,
    output logic            wb_req
);

    logic [AW-1:0] inc_val;
    logic [AW-1:0] dec_val;
    logic [AW-1:0] off_val;

    assign inc_val = ptr + AW'(1);
    assign dec_val = ptr - AW'(1);
    assign off_val = ptr + AW'(disp);

    always_comb begin
        addr     = ptr;
        next_ptr = ptr;
        wb_req   = 1'b0;
        unique case (mode)
            AM_POSTINC, AM_PM_POSTINC: begin
                next_ptr = inc_val;
                wb_req   = 1'b1;
            end
            AM_PREDEC: begin
                addr     = dec_val;
                next_ptr = dec_val;
                wb_req   = 1'b1;
            end
            AM_DISP: begin
                addr = off_val;
            end
            AM_IND, AM_PM_READ, AM_SPARE6, AM_SPARE7: begin
                addr = ptr;
            end
        endcase
    end

endmodule

// File: rtl/agu_region_map.sv
module agu_region_map
    import agu_pkg::*;
#(
    parameter int AW      = 16,
    parameter int RF_SIZE = 32,
    parameter int IO_SIZE = 64
) (
    input  logic [AW-1:0] addr,
    input  logic          pm_access,
    output region_t       region
);

    localparam logic [AW-1:0] IO_START  = AW'(RF_SIZE);
    localparam logic [AW-1:0] RAM_START = AW'(RF_SIZE + IO_SIZE);

    always_comb begin
        if (pm_access) begin
            region = RG_PROG;
        end else if (addr < IO_START) begin
            region = RG_REGFILE;
        end else if (addr < RAM_START) begin
            region = RG_IO;
        end else begin
            region = RG_RAM;
        end
    end

endmodule

// File: rtl/agu_pair_index.sv
module agu_pair_index
    import agu_pkg::*;
#(
    parameter int IW       = 5,
    parameter int PTR_BASE = 26
) (
    input  logic [1:0]    sel,
    input  logic          pm_access,
    output logic [IW-1:0] lo_idx,
    output logic [IW-1:0] hi_idx
);

    localparam logic [1:0] SEL_TOP = 2'd2;

    logic [1:0] sel_eff;

    always_comb begin
        if (pm_access || (sel > SEL_TOP)) begin
            sel_eff = SEL_TOP;
        end else begin
            sel_eff = sel;
        end
    end

    assign lo_idx = IW'(PTR_BASE) + IW'({sel_eff, 1'b0});
    assign hi_idx = lo_idx + IW'(1);

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
    import agu_pkg::*;
#(
    parameter int AW       = 16,
    parameter int QW       = 6,
    parameter int NREGS    = 32,
    parameter int RF_SIZE  = 32,
    parameter int IO_SIZE  = 64,
    parameter int PTR_BASE = 26,
    localparam int IW      = $clog2(NREGS),
    localparam int BW      = AW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [2:0]    mode,
    input  logic [1:0]    ptr_sel,
    input  logic [QW-1:0] disp,
    input  logic [AW-1:0] ptr_val,
    output logic          out_valid,
    output logic [AW-1:0] ea,
    output logic [1:0]    region,
    output logic [AW-2:0] pm_word,
    output logic          pm_hi_byte,
    output logic [AW-1:0] wb_data,
    output logic          wb_lo_en,
    output logic          wb_hi_en,
    output logic [IW-1:0] wb_lo_idx,
    output logic [IW-1:0] wb_hi_idx
);

    agu_state_t    state_q;
    agu_state_t    state_d;
    amode_t        mode_e;
    logic          pm_access;
    logic [AW-1:0] addr_c;
    logic [AW-1:0] next_c;
    logic          wb_req_c;
    region_t       region_c;
    logic [IW-1:0] lo_idx_c;
    logic [IW-1:0] hi_idx_c;
    logic          hi_change_c;

    assign mode_e    = amode_t'(mode);
    assign pm_access = is_pm_mode(mode_e);

    agu_pointer_math #(.AW(AW), .QW(QW)) u_math (
        .mode     (mode_e),
        .ptr      (ptr_val),
        .disp     (disp),
        .addr     (addr_c),
        .next_ptr (next_c),
        .wb_req   (wb_req_c)
    );

    agu_region_map #(.AW(AW), .RF_SIZE(RF_SIZE), .IO_SIZE(IO_SIZE)) u_region (
        .addr      (addr_c),
        .pm_access (pm_access),
        .region    (region_c)
    );

    agu_pair_index #(.IW(IW), .PTR_BASE(PTR_BASE)) u_index (
        .sel       (ptr_sel),
        .pm_access (pm_access),
        .lo_idx    (lo_idx_c),
        .hi_idx    (hi_idx_c)
    );

    assign hi_change_c = wb_req_c && (next_c[AW-1:BW] != ptr_val[AW-1:BW]);

    // next-state selection: GO, REPEAT, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req)  state_d = ST_ISSUE;
            ST_ISSUE: if (!req) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea         <= '0;
            region     <= RG_REGFILE;
            pm_word    <= '0;
            pm_hi_byte <= 1'b0;
            wb_data    <= '0;
            wb_lo_en   <= 1'b0;
            wb_hi_en   <= 1'b0;
            wb_lo_idx  <= '0;
            wb_hi_idx  <= '0;
        end else begin
            wb_lo_en <= req && wb_req_c;
            wb_hi_en <= req && hi_change_c;
            if (req) begin
                ea         <= addr_c;
                region     <= region_c;
                pm_word    <= addr_c[AW-1:1];
                pm_hi_byte <= addr_c[0];
                wb_data    <= next_c;
                wb_lo_idx  <= lo_idx_c;
                wb_hi_idx  <= hi_idx_c;
            end
        end
    end

    assign out_valid = (state_q == ST_ISSUE);

endmodule

// File: rtl/ptr_agu_checker.sv
module ptr_agu_checker #(
    parameter int AW = 16,
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          out_valid,
    input logic [AW-1:0] ea,
    input logic [1:0]    region,
    input logic [AW-2:0] pm_word,
    input logic          pm_hi_byte,
    input logic [AW-1:0] wb_data,
    input logic          wb_lo_en,
    input logic          wb_hi_en,
    input logic [IW-1:0] wb_lo_idx,
    input logic [IW-1:0] wb_hi_idx
);

    AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> out_valid); // R2

    AST_IDLE_GIVES_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!out_valid && !wb_lo_en && !wb_hi_en)); // R2

    AST_HI_WITH_LO: assert property (@(posedge clk) disable iff (!rst_n)
        wb_hi_en |-> wb_lo_en); // R8

    AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (wb_hi_idx == wb_lo_idx + IW'(1))); // R3

    AST_PM_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && region == 2'd3) |-> ({pm_word, pm_hi_byte} == ea)); // R10

    AST_WB_NEAR_EA: assert property (@(posedge clk) disable iff (!rst_n)
        wb_lo_en |-> ((wb_data == ea) || (wb_data == ea + AW'(1)))); // R5

    AST_REGFILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && region == 2'd0) |-> (ea < AW'(32))); // R9

endmodule

bind ptr_agu ptr_agu_checker #(.AW(AW), .IW(IW)) i_ptr_agu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .out_valid  (out_valid),
    .ea         (ea),
    .region     (region),
    .pm_word    (pm_word),
    .pm_hi_byte (pm_hi_byte),
    .wb_data    (wb_data),
    .wb_lo_en   (wb_lo_en),
    .wb_hi_en   (wb_hi_en),
    .wb_lo_idx  (wb_lo_idx),
    .wb_hi_idx  (wb_hi_idx)
);

// File: tb/test_ptr_agu.sv
module test_ptr_agu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  ptr_sel = '0;
    logic [5:0]  disp = '0;
    logic [15:0] ptr_val = '0;
    logic        out_valid;
    logic [15:0] ea;
    logic [1:0]  region;
    logic [14:0] pm_word;
    logic        pm_hi_byte;
    logic [15:0] wb_data;
    logic        wb_lo_en;
    logic        wb_hi_en;
    logic [4:0]  wb_lo_idx;
    logic [4:0]  wb_hi_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected results of the request applied in the previous cycle
    int e_valid = 0, e_ea = 0, e_reg = 0, e_wb = 0, e_lo_en = 0, e_hi_en = 0;
    int e_lo_idx = 0;

    always #5 clk = ~clk;

    ptr_agu i_ptr_agu (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .ptr_sel(ptr_sel),
        .disp(disp), .ptr_val(ptr_val), .out_valid(out_valid), .ea(ea),
        .region(region), .pm_word(pm_word), .pm_hi_byte(pm_hi_byte),
        .wb_data(wb_data), .wb_lo_en(wb_lo_en), .wb_hi_en(wb_hi_en),
        .wb_lo_idx(wb_lo_idx), .wb_hi_idx(wb_hi_idx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input int m);
        case (m)
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R10";
            5: return "R11";
            default: return "R4";
        endcase
    endfunction

    task automatic compare(input int m);
        chk("R2 out_valid", int'(out_valid), e_valid);
        chk("R8 wb_lo_en", int'(wb_lo_en), e_lo_en);
        chk("R8 wb_hi_en", int'(wb_hi_en), e_hi_en);
        if (e_valid != 0) begin
            chk({mode_tag(m), " ea"}, int'(ea), e_ea);
            chk((m == 4 || m == 5) ? "R10 region" : "R9 region", int'(region), e_reg);
            chk("R3 wb_lo_idx", int'(wb_lo_idx), e_lo_idx);
            chk("R3 wb_hi_idx", int'(wb_hi_idx), e_lo_idx + 1);
            if (e_lo_en != 0) chk({mode_tag(m), " wb_data"}, int'(wb_data), e_wb);
            if (e_reg == 3) begin
                chk("R10 pm_word", int'(pm_word), e_ea >> 1);
                chk("R10 pm_hi_byte", int'(pm_hi_byte), e_ea & 1);
            end
        end
    endtask

    task automatic model(input int r, input int m, input int s, input int q, input int p);
        int sel;
        int wbreq;
        e_valid = r;
        e_ea = p;
        wbreq = 0;
        e_wb = p;
        if (m == 1 || m == 5) begin e_wb = (p + 1) & 16'hFFFF; wbreq = 1; end
        if (m == 2) begin e_ea = (p - 1) & 16'hFFFF; e_wb = e_ea; wbreq = 1; end
        if (m == 3) e_ea = (p + q) & 16'hFFFF;
        if (m == 4 || m == 5) e_reg = 3;
        else if (e_ea < 32) e_reg = 0;
        else if (e_ea < 96) e_reg = 1;
        else e_reg = 2;
        sel = (m == 4 || m == 5 || s == 3) ? 2 : s;
        e_lo_idx = 26 + 2 * sel;
        e_lo_en = r & wbreq;
        e_hi_en = (r != 0 && wbreq != 0 && ((e_wb >> 8) != (p >> 8))) ? 1 : 0;
    endtask

    // compare the previous request, then drive and model the next one
    task automatic step(input int r, input int m, input int s, input int q, input int p);
        @(negedge clk);
        compare(int'(mode));
        req = r[0]; mode = m[2:0]; ptr_sel = s[1:0]; disp = q[5:0]; ptr_val = p[15:0];
        model(r, m, s, q, p);
    endtask

    int pts[10] = '{16'h0000, 16'hFFFF, 16'h00FF, 16'h0100, 31, 32, 95, 96, 16'h1234, 16'hFFC5};
    int qs[3] = '{0, 63, 1};

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 wb_lo_en in reset", int'(wb_lo_en), 0);
        chk("R1 wb_hi_en in reset", int'(wb_hi_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 wb_hi_en after reset", int'(wb_hi_en), 0);
        model(0, 0, 0, 0, 0);
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int pi = 0; pi < 10; pi++) begin
                    for (int qi = 0; qi < 3; qi++) begin
                        step(1, m, s, qs[qi], pts[pi]);
                    end
                end
                step(0, m, s, 5, 16'h4321);
            end
        end
        // region edges reached through pre-decrement and displacement
        step(1, 2, 0, 0, 32);
        step(1, 2, 1, 0, 96);
        step(1, 3, 1, 63, 95 - 63 + 1);
        step(1, 3, 2, 1, 31);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule